// File: doc/BRIEF.md
# Battery Lockout and Fault Flag Aggregator

This block sits between the digitised supply monitors of a low-side gate predriver and its serial control port. It takes an over-voltage indication, an optional under-voltage indication and one load-fault bit per output channel. From these it produces a global inhibit that forces every gate output off during a supply fault, a fault word that the serial shifter sends out when a read frame begins, and an interrupt flag modelled as an open-drain pin: an active-low level plus an output enable, so several devices can share one wire.

The active-low chip select controls when the fault word may change. While it is high, the word follows the live fault state one clock later. While it is low, the word is frozen. The rising edge clears the word for one cycle, after which it follows the live state again. The flag rises as soon as any fault appears. It stays asserted after the fault is gone and is released only on a chip-select falling edge that finds no fault present.

A parameter removes the under-voltage path for a variant without that monitor. After reset the flag is asserted and the word reports an under-voltage (only when that path is present), so the host starts with one dummy read frame.

Top module: `batt_fault_agg`

## Requirements
- R1: While `ov_i` is high, `chan_inhibit_o` is high in the same cycle, and with chip select high `snap_o[7]` is 1 one clock later.
- R2: With `UV_PATH`=1, `uv_i` high drives `chan_inhibit_o` high in the same cycle and sets `snap_o[6]` one clock later. With `UV_PATH`=0, `uv_i` has no effect: `snap_o[6]` stays 0 and `chan_inhibit_o` stays low.
- R3: While a battery fault (over-voltage, or under-voltage when enabled) is present, `snap_o[5:0]` reads 0. Channel faults reappear in the word once the battery fault clears.
- R4: While chip select is high and no rising edge occurs, `snap_o` equals the live word of the previous cycle, including bits that clear.
- R5: The word captured is the live word of the last cycle before the falling edge. While chip select stays low, `snap_o` does not change. A fault present only before that last cycle is not reported.
- R6: `flag_oe_o` is high in the same cycle as any live load or battery fault.
- R7: Once asserted, `flag_oe_o` stays high until the clock after a chip-select falling edge. That edge releases it only if no fault is live at the edge.
- R8: A chip-select rising edge makes `snap_o` read 0 in the following cycle.
- R9: `chan_inhibit_o` returns low in the same cycle that the battery fault clears.
- R10: Reset state: `chan_inhibit_o`=0, `snap_o`=8'h40 and `flag_oe_o`=1 when `UV_PATH`=1; `snap_o`=0 and `flag_oe_o`=0 when `UV_PATH`=0.
- R11: Whenever `flag_oe_o` is 1, `flag_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ov_i | input | 1 | Supply over-voltage indication |
| uv_i | input | 1 | Supply under-voltage indication |
| load_flt_i | input | 6 | Live load-fault bit per channel |
| cs_n_i | input | 1 | Serial chip select, active low |
| chan_inhibit_o | output | 1 | Forces all gate outputs off |
| snap_o | output | 8 | Fault word: [7] over-voltage, [6] under-voltage, [5:0] channels |
| flag_n_o | output | 1 | Interrupt level, active low |
| flag_oe_o | output | 1 | Interrupt pin enable; high pulls the shared line low |

## Verification
The inhibit and the assertion of the flag are combinational, so the bench checks them 1 ns after changing an input, before any clock edge. The fault word and the flag release each pass through one register, so they are checked 1 ns after the first rising edge that sees the stimulus. A chip-select edge is detected by comparing the pin with its value one clock earlier, so its effect is visible after the edge at which the new level is first sampled. Inputs are changed 1 ns after an edge and never at an edge, so no sample falls on a race.

// File: rtl/batt_fault_agg.sv
module batt_fault_agg #(
  parameter int NCH     = 6,
  parameter bit UV_PATH = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ov_i,
  input  logic           uv_i,
  input  logic [NCH-1:0] load_flt_i,
  input  logic           cs_n_i,
  output logic           chan_inhibit_o,
  output logic [NCH+1:0] snap_o,
  output logic           flag_n_o,
  output logic           flag_oe_o
);
  localparam int W = NCH + 2;
  localparam logic [W-1:0] SNAP_RST = UV_PATH ? W'(1) << NCH : '0;

  logic           uv_eff, batt_flt, any_flt;
  logic [W-1:0]   live_word, snap_q;
  logic           cs_q, flag_q;
  logic           cs_rise, cs_fall;

  assign uv_eff    = UV_PATH & uv_i;
  assign batt_flt  = ov_i | uv_eff;
  assign live_word = {ov_i, uv_eff, batt_flt ? {NCH{1'b0}} : load_flt_i};
  assign any_flt   = batt_flt | (|load_flt_i);
  assign cs_rise   = cs_n_i & ~cs_q;
  assign cs_fall   = ~cs_n_i & cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      snap_q <= SNAP_RST;
      flag_q <= UV_PATH;
    end else begin
      cs_q <= cs_n_i;
      if (cs_rise)     snap_q <= '0;
      else if (cs_n_i) snap_q <= live_word;
      if (cs_fall) flag_q <= any_flt;
      else         flag_q <= flag_q | any_flt;
    end
  end

  assign chan_inhibit_o = batt_flt;
  assign snap_o         = snap_q;
  assign flag_oe_o      = flag_q | any_flt;
  assign flag_n_o       = ~flag_oe_o;
endmodule

// File: rtl/batt_fault_chk.sv
module batt_fault_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] load_flt_i,
  input logic           cs_n_i,
  input logic           chan_inhibit_o,
  input logic [NCH+1:0] snap_o,
  input logic           flag_n_o,
  input logic           flag_oe_o
);
  AST_FLAG_REALTIME: assert property (@(posedge clk) disable iff (!rst_n)
    ((|load_flt_i) || chan_inhibit_o) |-> flag_oe_o); // R6

  AST_PIN_LOW_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    flag_oe_o |-> !flag_n_o); // R11

  AST_HOLD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && $past(!cs_n_i)) |-> $stable(snap_o)); // R5

  AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(!cs_n_i)) |=> (snap_o == '0)); // R8

  AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_oe_o) |-> ($past(!cs_n_i) && $past(cs_n_i, 2))); // R7

  AST_LOAD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chan_inhibit_o) && $past(cs_n_i) && $past(cs_n_i, 2)) |-> (snap_o[NCH-1:0] == '0)); // R3
endmodule

bind batt_fault_agg batt_fault_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_flt_i(load_flt_i), .cs_n_i(cs_n_i),
  .chan_inhibit_o(chan_inhibit_o), .snap_o(snap_o),
  .flag_n_o(flag_n_o), .flag_oe_o(flag_oe_o)
);

// File: tb/sim_batt_fault_agg.sv
`timescale 1ns/1ps
module sim_batt_fault_agg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ov = 1'b0, uv = 1'b0, cs_n = 1'b1;
  logic [5:0] load = '0;
  logic       inh, flag_n, flag_oe, inh1, flag_n1, flag_oe1;
  logic [7:0] snap, snap1;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  batt_fault_agg #(.NCH(6), .UV_PATH(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .ov_i(ov), .uv_i(uv), .load_flt_i(load),
    .cs_n_i(cs_n), .chan_inhibit_o(inh), .snap_o(snap),
    .flag_n_o(flag_n), .flag_oe_o(flag_oe));

  batt_fault_agg #(.NCH(6), .UV_PATH(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .ov_i(ov), .uv_i(uv), .load_flt_i(load),
    .cs_n_i(cs_n), .chan_inhibit_o(inh1), .snap_o(snap1),
    .flag_n_o(flag_n1), .flag_oe_o(flag_oe1));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic frame();
    cs_n = 1'b0; tick();
    cs_n = 1'b1; tick();
  endtask

  task automatic t_reset();
    check("R10 inhibit", {7'd0, inh}, 8'h00);
    check("R10 word", snap, 8'h40);
    check("R10 flag", {7'd0, flag_oe}, 8'h01);
    check("R11 pin", {7'd0, flag_n}, 8'h00);
    check("R10 word no-uv", snap1, 8'h00);
    check("R10 flag no-uv", {7'd0, flag_oe1}, 8'h00);
    tick();
    cs_n = 1'b0; tick();
    check("R7 dummy release", {7'd0, flag_oe}, 8'h00);
    check("R11 pin off", {7'd0, flag_n}, 8'h01);
    cs_n = 1'b1; tick();
    check("R8 cleared", snap, 8'h00);
  endtask

  task automatic t_overvolt();
    ov = 1'b1; #1;
    check("R1 inhibit", {7'd0, inh}, 8'h01);
    check("R6 flag", {7'd0, flag_oe}, 8'h01);
    tick();
    check("R1 word", snap, 8'h80);
    load = 6'h05; tick();
    check("R3 masked", snap, 8'h80);
    ov = 1'b0; #1;
    check("R9 inhibit off", {7'd0, inh}, 8'h00);
    tick();
    check("R3 resumed", snap, 8'h05);
    load = 6'h00; tick();
    check("R4 clears", snap, 8'h00);
    check("R7 sticky", {7'd0, flag_oe}, 8'h01);
    frame();
    check("R7 released", {7'd0, flag_oe}, 8'h00);
  endtask

  task automatic t_undervolt();
    uv = 1'b1; #1;
    check("R2 inhibit", {7'd0, inh}, 8'h01);
    check("R2 inhibit no-uv", {7'd0, inh1}, 8'h00);
    tick();
    check("R2 word", snap, 8'h40);
    check("R2 word no-uv", snap1, 8'h00);
    check("R2 flag no-uv", {7'd0, flag_oe1}, 8'h00);
    uv = 1'b0; tick();
    check("R9 uv gone", {7'd0, inh}, 8'h00);
    frame();
  endtask

  task automatic t_vanish();
    load = 6'h08; tick();
    load = 6'h00; tick();
    cs_n = 1'b0; tick();
    check("R5 not reported", snap, 8'h00);
    check("R7 release", {7'd0, flag_oe}, 8'h00);
    cs_n = 1'b1; tick();
  endtask

  task automatic t_capture();
    load = 6'h12; tick();
    check("R4 follow", snap, 8'h12);
    cs_n = 1'b0; tick();
    check("R5 captured", snap, 8'h12);
    check("R7 held live", {7'd0, flag_oe}, 8'h01);
    load = 6'h21; tick(); tick();
    check("R5 frozen", snap, 8'h12);
    cs_n = 1'b1; tick();
    check("R8 rise clear", snap, 8'h00);
    tick();
    check("R4 after rise", snap, 8'h21);
    load = 6'h00; tick();
    check("R4 drop", snap, 8'h00);
    check("R7 still set", {7'd0, flag_oe}, 8'h01);
    frame();
    check("R7 final", {7'd0, flag_oe}, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; #1;
    t_reset();
    t_overvolt();
    t_undervolt();
    t_vanish();
    t_capture();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule